// File: doc/BRIEF.md
# Instruction Fetch-Decode Timing Sequencer

This block is the timing and control core of a small 16-bit accumulator machine. A four-bit step counter is decoded into one-hot timing lines, and these lines generate the control strobes for the first part of every instruction: fetch, decode and the optional indirect-address read. The strobes include the three-bit select for the shared data bus, load enables for the address and instruction registers, the program-counter increment and the memory read. The block holds the program counter, the address register, the instruction register and the indirect flag.

At step 3 the block dispatches the instruction to one of four paths. The choice is made from the top decoded opcode line and the indirect flag: an indirect operand fetch, a direct operand, a register-reference instruction or an I/O instruction. Execution units, which sit outside this block, run the operation itself. They end a memory-reference sequence by pulsing the step-counter clear. A run flag gates all counting. A halt request clears the flag and a start request sets it again. Memory sits outside the block, and its read data is taken combinationally at the address register.

Top module: `fdseq_core`

## Requirements
- R1: After reset (asynchronous, active low, released on the second rising clock edge after `rst_n` rises), the run flag is 1. The timing lines show step 0, the program counter holds `RESET_PC` (default 0x010), and the address register, instruction register and indirect flag are 0.
- R2: In step 0 while running, the bus select is 3'b010 (program counter) and `ar_ld_o` is 1. After the edge, the memory address equals the earlier program counter.
- R3: In step 1 while running, the bus select is 3'b111 (memory), and `mem_rd_o`, `ir_ld_o` and `pc_inr_o` are all 1. After the edge, the instruction register holds the memory word and the program counter has gone up by one.
- R4: In step 2 while running, the bus select is 3'b101 (instruction register) and `ar_ld_o` is 1. After the edge, the address register holds instruction bits 11:0 and the indirect flag holds bit 15.
- R5: `d_o` is the one-hot decode of instruction bits 14:12: bit n is set for opcode n.
- R6: In step 3 with opcode not 7 and indirect flag 1, `ind_ld_o` is 1, the bus select is 3'b111, and `mem_rd_o` and `ar_ld_o` are 1. After the edge, the address register holds the low 12 bits of the word that was read.
- R7: In step 3 with opcode not 7, `mref_go_o` is 1 and the counter moves on to step 4. With the indirect flag 0, no load, read or increment strobe is active and the address register keeps its value.
- R8: In step 3 with opcode 7, `rref_exec_o` (indirect flag 0) or `io_exec_o` (indirect flag 1) is 1 for that one cycle, and the counter returns to step 0 at the next edge.
- R9: While running, `sc_clr_i` forces the counter to step 0 at the next edge and takes priority over the increment. Register transfers in that cycle still happen.
- R10: While running with no clear, the counter advances by one step on every edge and wraps from step 15 to step 0. Exactly one timing line is high at all times.
- R11: `halt_i` clears the run flag at the edge, and it wins over `start_i`. While the flag is 0, the counter holds even if `sc_clr_i` is 1, and all strobes and dispatch outputs are 0. `start_i` sets the flag again without moving the counter on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sets the run flag |
| halt_i | input | 1 | Clears the run flag (priority over start) |
| sc_clr_i | input | 1 | Step-counter clear from execution units |
| mem_rdata_i | input | WORD_W | Memory word at `mem_addr_o` |
| mem_addr_o | output | ADDR_W | Address register, drives memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| bus_sel_o | output | 3 | Shared bus source select |
| bus_o | output | WORD_W | Shared bus value |
| ar_ld_o | output | 1 | Address register load |
| ir_ld_o | output | 1 | Instruction register load |
| pc_inr_o | output | 1 | Program counter increment |
| pc_o | output | ADDR_W | Program counter |
| ir_o | output | WORD_W | Instruction register |
| ind_o | output | 1 | Indirect flag |
| d_o | output | 2**OPC_W | One-hot opcode decode |
| t_o | output | 2**SC_W | One-hot timing lines |
| run_o | output | 1 | Run flag |
| ind_ld_o | output | 1 | Step-3 indirect operand-address read |
| mref_go_o | output | 1 | Step-3 memory-reference continue |
| rref_exec_o | output | 1 | Step-3 register-reference execute |
| io_exec_o | output | 1 | Step-3 I/O execute |

## Verification
The bench sweeps all sixteen combinations of opcode and indirect flag through full instruction cycles and computes each register value arithmetically. A design that swapped the dispatch paths would misroute opcode 7 or send a direct operand through an extra memory read, and the step-3 and step-4 checks would catch either error. An extra increment, or a clear that did not take priority, would break the wrap run from step 15 back to step 0 and the clear check in step 1. Two halt cases are covered: a clear arriving while halted and a simultaneous start and halt. A design that kept counting, kept strobing or let start win would advance the timing lines or the program counter while stopped.

// File: rtl/fdseq_pkg.sv
package fdseq_pkg;
  localparam int WORD_W_D = 16;
  localparam int ADDR_W_D = 12;
  localparam int OPC_W_D  = 3;
  localparam int SC_W_D   = 4;

  typedef enum logic [2:0] {
    BUS_NONE = 3'b000,
    BUS_AR   = 3'b001,
    BUS_PC   = 3'b010,
    BUS_IR   = 3'b101,
    BUS_MEM  = 3'b111
  } bus_sel_e;
endpackage

// File: rtl/fdseq_timer.sv
module fdseq_timer #(
  parameter int SC_W = fdseq_pkg::SC_W_D,
  localparam int NT = 1 << SC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_i,
  input  logic          start_i,
  input  logic          clr_i,
  output logic          run_o,
  output logic [NT-1:0] t_o
);
  logic [SC_W-1:0] sc_q, sc_nxt;
  logic            s_q, s_nxt;

  always_comb begin
    if (halt_i)       s_nxt = 1'b0;
    else if (start_i) s_nxt = 1'b1;
    else              s_nxt = s_q;

    if (!s_q)         sc_nxt = sc_q;
    else if (clr_i)   sc_nxt = '0;
    else              sc_nxt = sc_q + SC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= 1'b1;
      sc_q <= '0;
    end else begin
      s_q  <= s_nxt;
      sc_q <= sc_nxt;
    end
  end

  for (genvar k = 0; k < NT; k++) begin : g_tdec
    assign t_o[k] = (sc_q == SC_W'(k));
  end

  assign run_o = s_q;
endmodule

// File: rtl/fdseq_dispatch.sv
module fdseq_dispatch #(
  parameter int OPC_W = fdseq_pkg::OPC_W_D,
  localparam int NOPC = 1 << OPC_W
) (
  input  logic [OPC_W-1:0] opc_i,
  input  logic             ind_i,
  input  logic             t3_i,
  input  logic             run_i,
  output logic [NOPC-1:0]  d_o,
  output logic             ind_ld_o,
  output logic             mref_go_o,
  output logic             rref_exec_o,
  output logic             io_exec_o
);
  for (genvar k = 0; k < NOPC; k++) begin : g_odec
    assign d_o[k] = (opc_i == OPC_W'(k));
  end

  logic en, d_top;
  assign en    = run_i & t3_i;
  assign d_top = d_o[NOPC-1];

  assign ind_ld_o    = en & ~d_top &  ind_i;
  assign mref_go_o   = en & ~d_top;
  assign rref_exec_o = en &  d_top & ~ind_i;
  assign io_exec_o   = en &  d_top &  ind_i;
endmodule

// File: rtl/fdseq_datapath.sv
module fdseq_datapath #(
  parameter int WORD_W = fdseq_pkg::WORD_W_D,
  parameter int ADDR_W = fdseq_pkg::ADDR_W_D,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fdseq_pkg::bus_sel_e bus_sel_i,
  input  logic                ar_ld_i,
  input  logic                ir_ld_i,
  input  logic                pc_inr_i,
  input  logic                ind_ld_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic [WORD_W-1:0]   bus_o,
  output logic [ADDR_W-1:0]   ar_o,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [WORD_W-1:0]   ir_o,
  output logic                ind_o
);
  import fdseq_pkg::*;

  logic [ADDR_W-1:0] ar_q, ar_nxt, pc_q, pc_nxt;
  logic [WORD_W-1:0] ir_q, ir_nxt;
  logic              ind_q, ind_nxt;

  always_comb begin
    case (bus_sel_i)
      BUS_AR:  bus_o = WORD_W'(ar_q);
      BUS_PC:  bus_o = WORD_W'(pc_q);
      BUS_IR:  bus_o = ir_q;
      BUS_MEM: bus_o = mem_rdata_i;
      default: bus_o = '0;
    endcase
  end

  always_comb begin
    ar_nxt  = ar_ld_i  ? bus_o[ADDR_W-1:0]  : ar_q;
    ir_nxt  = ir_ld_i  ? bus_o              : ir_q;
    pc_nxt  = pc_inr_i ? pc_q + ADDR_W'(1)  : pc_q;
    ind_nxt = ind_ld_i ? ir_q[WORD_W-1]     : ind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q  <= '0;
      ir_q  <= '0;
      pc_q  <= RESET_PC;
      ind_q <= 1'b0;
    end else begin
      ar_q  <= ar_nxt;
      ir_q  <= ir_nxt;
      pc_q  <= pc_nxt;
      ind_q <= ind_nxt;
    end
  end

  assign ar_o  = ar_q;
  assign pc_o  = pc_q;
  assign ir_o  = ir_q;
  assign ind_o = ind_q;
endmodule

// File: rtl/fdseq_core.sv
module fdseq_core #(
  parameter int WORD_W = fdseq_pkg::WORD_W_D,
  parameter int ADDR_W = fdseq_pkg::ADDR_W_D,
  parameter int OPC_W  = fdseq_pkg::OPC_W_D,
  parameter int SC_W   = fdseq_pkg::SC_W_D,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h010,
  localparam int NT   = 1 << SC_W,
  localparam int NOPC = 1 << OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic              sc_clr_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic [2:0]        bus_sel_o,
  output logic [WORD_W-1:0] bus_o,
  output logic              ar_ld_o,
  output logic              ir_ld_o,
  output logic              pc_inr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [WORD_W-1:0] ir_o,
  output logic              ind_o,
  output logic [NOPC-1:0]   d_o,
  output logic [NT-1:0]     t_o,
  output logic              run_o,
  output logic              ind_ld_o,
  output logic              mref_go_o,
  output logic              rref_exec_o,
  output logic              io_exec_o
);
  import fdseq_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic     clr_all, ir_flag_ld;
  bus_sel_e bus_sel;

  assign clr_all = sc_clr_i | rref_exec_o | io_exec_o;

  fdseq_timer #(.SC_W(SC_W)) timer_i (
    .clk(clk), .rst_n(rst_int_n), .halt_i(halt_i), .start_i(start_i),
    .clr_i(clr_all), .run_o(run_o), .t_o(t_o)
  );

  fdseq_dispatch #(.OPC_W(OPC_W)) disp_i (
    .opc_i(ir_o[WORD_W-2 -: OPC_W]), .ind_i(ind_o), .t3_i(t_o[3]),
    .run_i(run_o), .d_o(d_o), .ind_ld_o(ind_ld_o), .mref_go_o(mref_go_o),
    .rref_exec_o(rref_exec_o), .io_exec_o(io_exec_o)
  );

  // fetch / decode / indirect strobes, one step at a time
  always_comb begin
    bus_sel    = BUS_NONE;
    ar_ld_o    = 1'b0;
    ir_ld_o    = 1'b0;
    pc_inr_o   = 1'b0;
    mem_rd_o   = 1'b0;
    ir_flag_ld = 1'b0;
    if (run_o) begin
      if (t_o[0]) begin
        bus_sel = BUS_PC;
        ar_ld_o = 1'b1;
      end else if (t_o[1]) begin
        bus_sel  = BUS_MEM;
        mem_rd_o = 1'b1;
        ir_ld_o  = 1'b1;
        pc_inr_o = 1'b1;
      end else if (t_o[2]) begin
        bus_sel    = BUS_IR;
        ar_ld_o    = 1'b1;
        ir_flag_ld = 1'b1;
      end else if (ind_ld_o) begin
        bus_sel  = BUS_MEM;
        mem_rd_o = 1'b1;
        ar_ld_o  = 1'b1;
      end
    end
  end

  fdseq_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) dp_i (
    .clk(clk), .rst_n(rst_int_n), .bus_sel_i(bus_sel), .ar_ld_i(ar_ld_o),
    .ir_ld_i(ir_ld_o), .pc_inr_i(pc_inr_o), .ind_ld_i(ir_flag_ld),
    .mem_rdata_i(mem_rdata_i), .bus_o(bus_o), .ar_o(mem_addr_o),
    .pc_o(pc_o), .ir_o(ir_o), .ind_o(ind_o)
  );

  assign bus_sel_o = bus_sel;
endmodule

// File: rtl/fdseq_core_chk.sv
module fdseq_core_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int NT     = 16,
  parameter int NOPC   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_o,
  input logic [NT-1:0]     t_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_rdata_i,
  input logic              sc_clr_i,
  input logic [2:0]        bus_sel_o,
  input logic              ar_ld_o,
  input logic              ir_ld_o,
  input logic              pc_inr_o,
  input logic              mem_rd_o,
  input logic [NOPC-1:0]   d_o,
  input logic              ind_ld_o,
  input logic              mref_go_o,
  input logic              rref_exec_o,
  input logic              io_exec_o
);
  p_t_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t_o) == 1);

  p_t_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_o && !sc_clr_i && !rref_exec_o && !io_exec_o
    |=> t_o == {$past(t_o[NT-2:0]), $past(t_o[NT-1])});

  p_t0_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_o && t_o[0] |-> bus_sel_o == 3'b010 && ar_ld_o);

  p_ar_from_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_o && t_o[0] |=> mem_addr_o == $past(pc_o));

  p_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_o && t_o[1] |=> pc_o == $past(pc_o) + ADDR_W'(1));

  p_dec_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(d_o) == 1);

  p_ind_ar_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ind_ld_o |=> mem_addr_o == $past(mem_rdata_i[ADDR_W-1:0]));

  p_mref_t4_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mref_go_o && !sc_clr_i |=> t_o[4]);

  p_ref_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rref_exec_o || io_exec_o |=> t_o[0]);

  p_path_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mref_go_o, rref_exec_o, io_exec_o}));

  p_clr_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_o && sc_clr_i |=> t_o[0]);

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> $stable(t_o) && $stable(pc_o));

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> !ar_ld_o && !ir_ld_o && !pc_inr_o && !mem_rd_o && !ind_ld_o
               && !mref_go_o && !rref_exec_o && !io_exec_o);
endmodule

bind fdseq_core fdseq_core_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NT(NT), .NOPC(NOPC)
) chk_i (
  .clk(clk), .rst_n(rst_int_n), .run_o(run_o), .t_o(t_o), .pc_o(pc_o),
  .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .sc_clr_i(sc_clr_i),
  .bus_sel_o(bus_sel_o), .ar_ld_o(ar_ld_o), .ir_ld_o(ir_ld_o),
  .pc_inr_o(pc_inr_o), .mem_rd_o(mem_rd_o), .d_o(d_o), .ind_ld_o(ind_ld_o),
  .mref_go_o(mref_go_o), .rref_exec_o(rref_exec_o), .io_exec_o(io_exec_o)
);

// File: tb/fdseq_core_tb_top.sv
module fdseq_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, start_i, halt_i, sc_clr_i;
  logic [15:0] mem [0:63];
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr, pc;
  logic        mem_rd, ar_ld, ir_ld, pc_inr, ind, run;
  logic        ind_ld, mref_go, rref_exec, io_exec;
  logic [2:0]  bus_sel;
  logic [15:0] bus, ir, t;
  logic [7:0]  d;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:0]];

  fdseq_core dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .halt_i(halt_i),
    .sc_clr_i(sc_clr_i), .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .bus_sel_o(bus_sel), .bus_o(bus), .ar_ld_o(ar_ld),
    .ir_ld_o(ir_ld), .pc_inr_o(pc_inr), .pc_o(pc), .ir_o(ir), .ind_o(ind),
    .d_o(d), .t_o(t), .run_o(run), .ind_ld_o(ind_ld), .mref_go_o(mref_go),
    .rref_exec_o(rref_exec), .io_exec_o(io_exec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // one full instruction cycle starting at step 0; wrap=1 lets the counter run to 15
  task automatic run_instr(input logic [11:0] pc_exp, input bit wrap);
    logic [15:0] ins;
    logic [2:0]  op;
    logic        ib;
    logic [11:0] adr, ptr;
    ins = mem[pc_exp[5:0]];
    op  = ins[14:12];
    ib  = ins[15];
    adr = ins[11:0];
    ptr = mem[adr[5:0]][11:0];
    chk("R10 step0 line", 32'(t), 32'h1);
    chk("R2 step0 strobes", 32'({bus_sel, ar_ld, ir_ld, pc_inr, mem_rd}), 32'b010_1000);
    chk("R2 pc before", 32'(pc), 32'(pc_exp));
    step;
    chk("R2 ar from pc", 32'(mem_addr), 32'(pc_exp));
    chk("R3 step1 strobes", 32'({bus_sel, ar_ld, ir_ld, pc_inr, mem_rd}), 32'b111_0111);
    step;
    chk("R3 ir loaded", 32'(ir), 32'(ins));
    chk("R3 pc incremented", 32'(pc), 32'(pc_exp + 12'd1));
    chk("R4 step2 strobes", 32'({bus_sel, ar_ld, ir_ld, pc_inr, mem_rd}), 32'b101_1000);
    step;
    chk("R4 ar from ir", 32'(mem_addr), 32'(adr));
    chk("R4 indirect flag", 32'(ind), 32'(ib));
    chk("R5 opcode decode", 32'(d), 32'(8'b1 << op));
    if (op != 3'd7) begin
      chk("R7 mref dispatch", 32'({mref_go, rref_exec, io_exec}), 32'b100);
      if (ib) begin
        chk("R6 indirect strobes",
            32'({ind_ld, bus_sel, ar_ld, mem_rd, ir_ld, pc_inr}), 32'b1_111_1100);
      end else begin
        chk("R7 direct no strobes",
            32'({ind_ld, ar_ld, mem_rd, ir_ld, pc_inr}), 32'b0);
      end
      step;
      chk(ib ? "R6 effective addr" : "R7 addr kept", 32'(mem_addr), 32'(ib ? ptr : adr));
      chk("R7 to step4", 32'(t), 32'h10);
      if (wrap) begin
        for (int n = 5; n < 16; n++) begin
          step;
          chk("R10 counting", 32'(t), 32'(16'h1 << n));
        end
        step;
        chk("R10 wrap to step0", 32'(t), 32'h1);
      end else begin
        step;
        chk("R10 step5", 32'(t), 32'h20);
        sc_clr_i = 1'b1;
        step;
        sc_clr_i = 1'b0;
        chk("R9 clear to step0", 32'(t), 32'h1);
      end
    end else begin
      chk("R8 ref/io dispatch",
          32'({mref_go, ind_ld, rref_exec, io_exec}), 32'({2'b00, ~ib, ib}));
      step;
      chk("R8 back to step0", 32'(t), 32'h1);
      chk("R8 addr kept", 32'(mem_addr), 32'(adr));
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; halt_i = 1'b0; sc_clr_i = 1'b0;
    for (int a = 0; a < 64; a++) mem[a] = 16'h0000;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] kk;
      kk = 4'(k);
      mem[16 + k] = {kk[0], kk[3:1], 12'h020 + 12'(k)};
      mem[32 + k] = 16'hA000 | 16'(12'h030 + 12'(k));
    end
    repeat (3) step;
    rst_n = 1'b1;
    step;
    step;
    // R1: internal reset just released, nothing has moved yet
    chk("R1 step0 after reset", 32'(t), 32'h1);
    chk("R1 run flag", 32'(run), 32'h1);
    chk("R1 reset vector", 32'(pc), 32'h010);
    chk("R1 regs cleared", 32'({mem_addr, ir, ind}), 32'h0);

    // sweep: every opcode with both indirect flag values
    for (int k = 0; k < 16; k++) run_instr(12'h010 + 12'(k), 1'b0);

    // R10 wrap: indirect memory-reference at 0x020 with no clear
    run_instr(12'h020, 1'b1);

    // R9: clear in step 1 wins over increment, transfers still occur
    step;
    sc_clr_i = 1'b1;
    step;
    sc_clr_i = 1'b0;
    chk("R9 clear in step1", 32'(t), 32'h1);
    chk("R9 pc still incremented", 32'(pc), 32'h022);
    run_instr(12'h022, 1'b0);

    // R11: halt in step 0
    halt_i = 1'b1;
    step;
    halt_i = 1'b0;
    chk("R11 halted", 32'({run, t}), 32'({1'b0, 16'h2}));
    sc_clr_i = 1'b1;
    step;
    sc_clr_i = 1'b0;
    chk("R11 clear ignored while halted", 32'(t), 32'h2);
    chk("R11 pc frozen", 32'(pc), 32'h023);
    chk("R11 strobes quiet",
        32'({ar_ld, ir_ld, pc_inr, mem_rd, ind_ld, mref_go, rref_exec, io_exec}), 32'h0);
    start_i = 1'b1; halt_i = 1'b1;
    step;
    halt_i = 1'b0;
    chk("R11 halt beats start", 32'(run), 32'h0);
    step;
    start_i = 1'b0;
    chk("R11 resumed in place", 32'({run, t, pc_inr}), 32'({1'b1, 16'h2, 1'b1}));
    step;
    chk("R11 fetch completes", 32'(ir), 32'(mem[35]));
    chk("R11 pc after resume", 32'(pc), 32'h024);
    for (int g = 0; g < 20 && !t[0]; g++) begin
      sc_clr_i = t[5];
      step;
    end
    sc_clr_i = 1'b0;
    chk("R11 cycle ends at step0", 32'(t), 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule